// File: doc/BRIEF.md
# Memory Command Arbiter

This block sits between the request flags of a processor's instruction and data caches and one shared command port toward memory. Each cycle it is idle, it looks at seven request sources and picks one. The sources are data read miss, data uncached read, data linked load, instruction miss, instruction uncached read, write-buffer flush and store-conditional. It then issues that request as one or more command flits and waits for each flit to be acknowledged. A fixed priority ladder orders the sources. An alternating turn bit keeps the data cache and the instruction cache from starving each other on misses. Some reads must not overtake a write still sitting in the write buffer: while the buffer reports a pending entry at the read's address, that read is held back.

The requesters hold level requests and drop them when they see their bit on the one-hot grant pulse. The linked-load request is the exception. The data side posts it with a one-cycle pulse, and the arbiter keeps it as a flag until it is granted. The write buffer is outside the block. It shows up only as two address-conflict flags (one for the data address, one for the instruction address), a ready flag, a word-index range, a line base address, and a read port addressed by the current word index.

Top module: `memcmd_arbiter`

## Requirements
- R1: When several sources are eligible in an idle cycle, exactly one grant bit is set, and it goes to the first eligible source in this order: data miss (bit 0), data uncached (bit 1), linked load (bit 2), instruction miss (bit 3), instruction uncached (bit 4), buffered write (bit 5), store-conditional (bit 6). The command carries the grant bit index as its packet type `cmd_pktid`.
- R2: The turn bit is clear after reset. Data miss, data uncached and linked load are eligible only if no instruction miss is pending or the turn bit is clear. Instruction miss is eligible only if none of those three is pending or the turn bit is set.
- R3: The turn bit flips on every grant of a data miss or an instruction miss, and on no other grant.
- R4: Data uncached and linked load are not granted while `wb_dhit` is high. Instruction miss is not granted while `wb_ihit` is high. The other sources ignore both flags.
- R5: A pulse on `ll_post` makes one linked load pending. Its grant clears it, so each pulse yields at most one linked-load command.
- R6: A linked-load command is one flit at the data address, with write data 0, all byte enables set, transaction id 0 and length 8 bytes.
- R7: A buffered-write grant sends max-min+1 flits for word indices min up to max, taken from `wb_min`/`wb_max` at grant. Flit i goes to line base + 4*i, with data and byte enables read from the buffer at `wb_rd_idx` = i. The length is (max-min+1)*4 bytes, and `cmd_eop` is set on the last flit only.
- R8: Miss commands go to the line-aligned address (low log2(4*LINE_WORDS) bits cleared) with length 4*LINE_WORDS. Uncached reads and store-conditional go to the given address with length 4. Store-conditional sends the `sc_wdata` value from grant time. Other reads send data 0. All non-write commands have every byte enable set. Transaction id is 1 for instruction sources and 0 otherwise, and each is one flit with `cmd_eop` set.
- R9: After reset, `cmd_valid` and `grant` are 0. Grants happen only while no command is in flight. A command's fields hold until acknowledged, whatever the inputs do meanwhile. After the last flit is acknowledged, `cmd_valid` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmiss_req | input | 1 | Data read miss pending |
| dunc_req | input | 1 | Data uncached read pending |
| ll_post | input | 1 | One-cycle pulse posting a linked load |
| imiss_req | input | 1 | Instruction miss pending |
| iunc_req | input | 1 | Instruction uncached read pending |
| sc_req | input | 1 | Store-conditional pending |
| d_paddr | input | ADDR_W | Data-side physical address |
| i_paddr | input | ADDR_W | Instruction-side physical address |
| sc_wdata | input | DATA_W | Store-conditional data |
| wb_dhit | input | 1 | Write buffer holds an entry matching `d_paddr` |
| wb_ihit | input | 1 | Write buffer holds an entry matching `i_paddr` |
| wb_rok | input | 1 | Write buffer has a range ready to flush |
| wb_min | input | IDX_W | First word index of the ready range |
| wb_max | input | IDX_W | Last word index of the ready range |
| wb_line | input | ADDR_W | Line base address of the ready range |
| wb_wdata | input | DATA_W | Buffer data at `wb_rd_idx` |
| wb_be | input | DATA_W/8 | Buffer byte enables at `wb_rd_idx` |
| wb_rd_idx | output | IDX_W | Word index being read from the buffer |
| grant | output | 7 | One-hot grant pulse, bit per source |
| cmd_valid | output | 1 | Command flit valid |
| cmd_ack | input | 1 | Command flit accepted |
| cmd_addr | output | ADDR_W | Flit address |
| cmd_wdata | output | DATA_W | Flit write data |
| cmd_be | output | DATA_W/8 | Flit byte enables |
| cmd_trdid | output | TRDID_W | Transaction id |
| cmd_pktid | output | 3 | Packet type (grant bit index) |
| cmd_plen | output | PLEN_W | Command length in bytes |
| cmd_eop | output | 1 | Last flit of the command |

## Verification
The case that matters most is a cycle where the turn bit and the write-buffer conflict check both act on the same pending requests. One example is a data miss and an instruction miss pending together while `wb_ihit` blocks the instruction side, so the turn bit's choice is overruled and a lower source wins. Random rounds raise all seven requests and both conflict flags independently in every idle cycle, and directed rounds set up these overlaps on purpose. Each grant is compared with a bench function that applies the turn rule and the conflict gates from the requirements, using a bench copy of the turn bit and the linked-load flag.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

    localparam int NUM_SRC = 7;

    // Grant bit positions; the order is the priority ladder.
    localparam int IX_DMISS = 0;
    localparam int IX_DUNC  = 1;
    localparam int IX_DLL   = 2;
    localparam int IX_IMISS = 3;
    localparam int IX_IUNC  = 4;
    localparam int IX_WRITE = 5;
    localparam int IX_SC    = 6;

    typedef enum logic [2:0] {
        SRC_DMISS = 3'd0,
        SRC_DUNC  = 3'd1,
        SRC_DLL   = 3'd2,
        SRC_IMISS = 3'd3,
        SRC_IUNC  = 3'd4,
        SRC_WRITE = 3'd5,
        SRC_SC    = 3'd6,
        SRC_NONE  = 3'd7
    } src_e;

    localparam int WORD_BYTES = 4;
    localparam int LL_BYTES   = 8;

endpackage

// File: rtl/memcmd_select.sv
module memcmd_select
    import memcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               iprio_i,
    input  logic               wb_dhit_i,
    input  logic               wb_ihit_i,
    input  logic               enable_i,
    output logic [NUM_SRC-1:0] grant_o,
    output src_e               sel_o
);

    logic [NUM_SRC-1:0] elig;
    logic               data_turn;
    logic               data_pend;
    logic               taken;

    // Eligibility: turn bit between the two cache sides, buffer conflicts.
    always_comb begin
        data_turn = !req_i[IX_IMISS] || !iprio_i;
        data_pend = req_i[IX_DMISS] || req_i[IX_DUNC] || req_i[IX_DLL];
        elig            = req_i;
        elig[IX_DMISS]  = req_i[IX_DMISS] && data_turn;
        elig[IX_DUNC]   = req_i[IX_DUNC]  && data_turn && !wb_dhit_i;
        elig[IX_DLL]    = req_i[IX_DLL]   && data_turn && !wb_dhit_i;
        elig[IX_IMISS]  = req_i[IX_IMISS] && (!data_pend || iprio_i) && !wb_ihit_i;
    end

    // Fixed ladder: the lowest eligible index wins.
    always_comb begin
        taken = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            grant_o[k] = enable_i && elig[k] && !taken;
            taken      = taken || elig[k];
        end
    end

    always_comb begin
        sel_o = SRC_NONE;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (grant_o[k]) sel_o = src_e'(3'(k));
        end
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_dgate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_dhit_i |-> !grant_o[IX_DUNC] && !grant_o[IX_DLL]);

    assert_igate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ihit_i |-> !grant_o[IX_IMISS]);

    assert_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iprio_i && req_i[IX_IMISS]) |->
            !grant_o[IX_DMISS] && !grant_o[IX_DUNC] && !grant_o[IX_DLL]);

endmodule

// File: rtl/memcmd_sequencer.sv
module memcmd_sequencer
    import memcmd_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int DATA_W     = 32,
    parameter  int LINE_WORDS = 16,
    parameter  int TRDID_W    = 4,
    localparam int IDX_W      = $clog2(LINE_WORDS),
    localparam int BE_W       = DATA_W / 8,
    localparam int PLEN_W     = $clog2(LINE_WORDS * WORD_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  src_e               src_i,
    input  logic [ADDR_W-1:0]  d_paddr_i,
    input  logic [ADDR_W-1:0]  i_paddr_i,
    input  logic [DATA_W-1:0]  sc_wdata_i,
    input  logic [IDX_W-1:0]   wb_min_i,
    input  logic [IDX_W-1:0]   wb_max_i,
    input  logic [ADDR_W-1:0]  wb_line_i,
    input  logic [DATA_W-1:0]  wb_wdata_i,
    input  logic [BE_W-1:0]    wb_be_i,
    input  logic               cmd_ack_i,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic               cmd_valid_o,
    output logic [ADDR_W-1:0]  cmd_addr_o,
    output logic [DATA_W-1:0]  cmd_wdata_o,
    output logic [BE_W-1:0]    cmd_be_o,
    output logic [TRDID_W-1:0] cmd_trdid_o,
    output logic [2:0]         cmd_pktid_o,
    output logic [PLEN_W-1:0]  cmd_plen_o,
    output logic               cmd_eop_o
);

    localparam int               LINE_BYTES = LINE_WORDS * WORD_BYTES;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

    typedef struct packed {
        logic              busy;
        src_e              src;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  first;
        logic [IDX_W-1:0]  last;
    } seq_t;

    seq_t st_d, st_q;
    logic is_wr;
    logic [PLEN_W-1:0] burst_words;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.src   = src_i;
                st_d.wdata = (src_i == SRC_SC) ? sc_wdata_i : '0;
                st_d.first = (src_i == SRC_WRITE) ? wb_min_i : '0;
                st_d.last  = (src_i == SRC_WRITE) ? wb_max_i : '0;
                st_d.idx   = st_d.first;
                case (src_i)
                    SRC_DMISS: st_d.addr = d_paddr_i & LINE_MASK;
                    SRC_IMISS: st_d.addr = i_paddr_i & LINE_MASK;
                    SRC_IUNC:  st_d.addr = i_paddr_i;
                    SRC_WRITE: st_d.addr = wb_line_i;
                    default:   st_d.addr = d_paddr_i;
                endcase
            end
        end else if (cmd_ack_i) begin
            if (st_q.idx == st_q.last) st_d.busy = 1'b0;
            else                       st_d.idx  = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        is_wr       = (st_q.src == SRC_WRITE);
        burst_words = PLEN_W'(st_q.last) - PLEN_W'(st_q.first) + PLEN_W'(1);
        rd_idx_o    = st_q.idx;
        cmd_valid_o = st_q.busy;
        cmd_addr_o  = is_wr ? st_q.addr + (ADDR_W'(st_q.idx) << 2) : st_q.addr;
        cmd_wdata_o = is_wr ? wb_wdata_i : st_q.wdata;
        cmd_be_o    = is_wr ? wb_be_i : '1;
        cmd_trdid_o = (st_q.src == SRC_IMISS || st_q.src == SRC_IUNC) ?
                      TRDID_W'(1) : '0;
        cmd_pktid_o = st_q.src;
        cmd_eop_o   = (st_q.idx == st_q.last);
        case (st_q.src)
            SRC_DMISS, SRC_IMISS: cmd_plen_o = PLEN_W'(LINE_BYTES);
            SRC_DLL:              cmd_plen_o = PLEN_W'(LL_BYTES);
            SRC_WRITE:            cmd_plen_o = burst_words << 2;
            default:              cmd_plen_o = PLEN_W'(WORD_BYTES);
        endcase
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ack_i) |=>
            cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_pktid_o)
            && $stable(cmd_plen_o));

    assert_llfields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_pktid_o == SRC_DLL) |->
            cmd_wdata_o == '0 && cmd_be_o == '1 && cmd_trdid_o == '0
            && cmd_plen_o == PLEN_W'(LL_BYTES) && cmd_eop_o);

    assert_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ack_i && !cmd_eop_o) |=>
            cmd_valid_o && cmd_addr_o == $past(cmd_addr_o) + ADDR_W'(WORD_BYTES));

    assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ack_i && cmd_eop_o) |=> !cmd_valid_o);

endmodule

// File: rtl/memcmd_arbiter.sv
module memcmd_arbiter
    import memcmd_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int DATA_W     = 32,
    parameter  int LINE_WORDS = 16,
    parameter  int TRDID_W    = 4,
    localparam int IDX_W      = $clog2(LINE_WORDS),
    localparam int BE_W       = DATA_W / 8,
    localparam int PLEN_W     = $clog2(LINE_WORDS * WORD_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dmiss_req,
    input  logic               dunc_req,
    input  logic               ll_post,
    input  logic               imiss_req,
    input  logic               iunc_req,
    input  logic               sc_req,
    input  logic [ADDR_W-1:0]  d_paddr,
    input  logic [ADDR_W-1:0]  i_paddr,
    input  logic [DATA_W-1:0]  sc_wdata,
    input  logic               wb_dhit,
    input  logic               wb_ihit,
    input  logic               wb_rok,
    input  logic [IDX_W-1:0]   wb_min,
    input  logic [IDX_W-1:0]   wb_max,
    input  logic [ADDR_W-1:0]  wb_line,
    input  logic [DATA_W-1:0]  wb_wdata,
    input  logic [BE_W-1:0]    wb_be,
    output logic [IDX_W-1:0]   wb_rd_idx,
    output logic [NUM_SRC-1:0] grant,
    output logic               cmd_valid,
    input  logic               cmd_ack,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [DATA_W-1:0]  cmd_wdata,
    output logic [BE_W-1:0]    cmd_be,
    output logic [TRDID_W-1:0] cmd_trdid,
    output logic [2:0]         cmd_pktid,
    output logic [PLEN_W-1:0]  cmd_plen,
    output logic               cmd_eop
);

    typedef struct packed {
        logic ll;      // linked load waiting
        logic iprio;   // instruction side has the turn
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_SRC-1:0] reqs;
    src_e               sel;

    assign reqs = {sc_req, wb_rok, iunc_req, imiss_req, ctl_q.ll, dunc_req, dmiss_req};

    memcmd_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (reqs),
        .iprio_i   (ctl_q.iprio),
        .wb_dhit_i (wb_dhit),
        .wb_ihit_i (wb_ihit),
        .enable_i  (!cmd_valid),
        .grant_o   (grant),
        .sel_o     (sel)
    );

    memcmd_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .TRDID_W    (TRDID_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (|grant),
        .src_i       (sel),
        .d_paddr_i   (d_paddr),
        .i_paddr_i   (i_paddr),
        .sc_wdata_i  (sc_wdata),
        .wb_min_i    (wb_min),
        .wb_max_i    (wb_max),
        .wb_line_i   (wb_line),
        .wb_wdata_i  (wb_wdata),
        .wb_be_i     (wb_be),
        .cmd_ack_i   (cmd_ack),
        .rd_idx_o    (wb_rd_idx),
        .cmd_valid_o (cmd_valid),
        .cmd_addr_o  (cmd_addr),
        .cmd_wdata_o (cmd_wdata),
        .cmd_be_o    (cmd_be),
        .cmd_trdid_o (cmd_trdid),
        .cmd_pktid_o (cmd_pktid),
        .cmd_plen_o  (cmd_plen),
        .cmd_eop_o   (cmd_eop)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ll    = ll_post || (ctl_q.ll && !grant[IX_DLL]);
        ctl_d.iprio = ctl_q.iprio ^ (grant[IX_DMISS] || grant[IX_IMISS]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[IX_DMISS] || grant[IX_IMISS]) |=> ctl_q.iprio != $past(ctl_q.iprio));

    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant[IX_DMISS] || grant[IX_IMISS]) |=> $stable(ctl_q.iprio));

    assert_llclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[IX_DLL] && !ll_post) |=> !ctl_q.ll);

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> grant == '0);

endmodule

// File: tb/memcmd_arbiter_test.sv
module memcmd_arbiter_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 16;
    localparam int IW = 4;
    localparam int PW = 7;
    localparam logic [31:0] LMASK = ~32'h3F;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          dmiss_req, dunc_req, ll_post, imiss_req, iunc_req, sc_req;
    logic [AW-1:0] d_paddr, i_paddr, wb_line, cmd_addr;
    logic [DW-1:0] sc_wdata, wb_wdata, cmd_wdata;
    logic          wb_dhit, wb_ihit, wb_rok, cmd_valid, cmd_ack, cmd_eop;
    logic [IW-1:0] wb_min, wb_max, wb_rd_idx;
    logic [3:0]    wb_be, cmd_be, cmd_trdid;
    logic [6:0]    grant;
    logic [2:0]    cmd_pktid;
    logic [PW-1:0] cmd_plen;

    memcmd_arbiter uut (.*);

    // Write-buffer read-port model.
    assign wb_wdata = 32'hC0DE_0000 | DW'(wb_rd_idx);
    assign wb_be    = {wb_rd_idx[1:0], 2'b11};

    int n_chk = 0;
    int n_bad = 0;
    bit m_iprio = 1'b0;
    bit m_ll    = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick(logic [6:0] r, bit ip, bit dh, bit ih);
        bit dok = !r[3] || !ip;
        bit [6:0] e;
        e    = r;
        e[0] = r[0] && dok;
        e[1] = r[1] && dok && !dh;
        e[2] = r[2] && dok && !dh;
        e[3] = r[3] && (!(r[0] || r[1] || r[2]) || ip) && !ih;
        for (int k = 0; k < 7; k++) if (e[k]) return k;
        return 7;
    endfunction

    task automatic quiet();
        dmiss_req = 0; dunc_req = 0; ll_post = 0; imiss_req = 0;
        iunc_req = 0; sc_req = 0; wb_rok = 0; wb_dhit = 1; wb_ihit = 0;
        cmd_ack = 0;
    endtask

    task automatic post_ll();
        if (m_ll) return;
        @(negedge clk);
        quiet();
        ll_post = 1;
        @(negedge clk);
        ll_post = 0;
        m_ll = 1;
    endtask

    task automatic check_flit(input int e, input int f, input int nfl,
                              input logic [31:0] base, input logic [31:0] scw,
                              input logic [IW-1:0] mn);
        string tag;
        logic [IW-1:0] idx;
        tag = (e == 2) ? "R6" : (e == 5) ? "R7" : "R8";
        idx = mn + IW'(f);
        chk("R9", "cmd_valid", 64'(cmd_valid), 64'd1);
        chk(tag, "cmd_addr", 64'(cmd_addr),
            64'((e == 5) ? base + 32'(idx) * 4 : base));
        chk("R1", "cmd_pktid", 64'(cmd_pktid), 64'(e));
        chk(tag, "cmd_plen", 64'(cmd_plen),
            64'((e == 0 || e == 3) ? 64 : (e == 2) ? 8 : (e == 5) ? nfl * 4 : 4));
        chk(tag, "cmd_trdid", 64'(cmd_trdid), 64'((e == 3 || e == 4) ? 1 : 0));
        chk(tag, "cmd_be", 64'(cmd_be), 64'((e == 5) ? {idx[1:0], 2'b11} : 4'hF));
        chk(tag, "cmd_wdata", 64'(cmd_wdata),
            64'((e == 6) ? scw : (e == 5) ? (32'hC0DE_0000 | 32'(idx)) : 32'h0));
        chk(tag, "cmd_eop", 64'(cmd_eop), 64'(f == nfl - 1));
        if (e == 5) chk("R7", "wb_rd_idx", 64'(wb_rd_idx), 64'(idx));
    endtask

    // One arbitration round; r[2] is ignored (linked load comes from ll_post).
    task automatic round(input logic [6:0] r, input bit dh, input bit ih,
                         input logic [IW-1:0] mn, input logic [IW-1:0] mx,
                         input string tag);
        logic [6:0]  rr;
        logic [31:0] base, scw;
        int e, nfl;
        @(negedge clk);
        dmiss_req = r[0]; dunc_req = r[1]; imiss_req = r[3]; iunc_req = r[4];
        wb_rok = r[5]; sc_req = r[6]; wb_dhit = dh; wb_ihit = ih;
        wb_min = mn; wb_max = mx;
        d_paddr = $urandom; i_paddr = $urandom;
        wb_line = $urandom & LMASK; sc_wdata = $urandom;
        #1;
        rr = r; rr[2] = m_ll;
        e = pick(rr, m_iprio, dh, ih);
        chk(tag, "grant", 64'(grant), 64'((e == 7) ? 7'd0 : 7'(1 << e)));
        case (e)
            0:       base = d_paddr & LMASK;
            3:       base = i_paddr & LMASK;
            4:       base = i_paddr;
            5:       base = wb_line;
            default: base = d_paddr;
        endcase
        scw = sc_wdata;
        nfl = (e == 5) ? int'(mx) - int'(mn) + 1 : 1;
        if (e == 0 || e == 3) m_iprio = !m_iprio;
        if (e == 2) m_ll = 0;
        @(negedge clk);
        quiet();
        d_paddr = $urandom; i_paddr = $urandom; wb_line = $urandom; sc_wdata = $urandom;
        if (e == 7) begin
            chk("R9", "cmd_valid idle", 64'(cmd_valid), 64'd0);
            return;
        end
        for (int f = 0; f < nfl; f++) begin
            while ($urandom_range(2) == 0) begin
                check_flit(e, f, nfl, base, scw, mn);
                @(negedge clk);
            end
            check_flit(e, f, nfl, base, scw, mn);
            cmd_ack = 1;
            @(negedge clk);
            cmd_ack = 0;
        end
        chk("R9", "cmd_valid gap", 64'(cmd_valid), 64'd0);
        chk("R9", "grant gap", 64'(grant), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] r;
        logic [IW-1:0] a, b;
        void'($urandom(32'd20240611));
        quiet();
        d_paddr = 0; i_paddr = 0; wb_line = 0; sc_wdata = 0; wb_min = 0; wb_max = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk("R9", "reset cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R9", "reset grant", 64'(grant), 64'd0);

        // R2 R3: data and instruction miss together take turns.
        round(7'b0001001, 0, 0, 0, 0, "R2");
        round(7'b0001001, 0, 0, 0, 0, "R3");
        round(7'b0001001, 0, 0, 0, 0, "R2");
        // R4: conflicts block uncached data and instruction miss.
        round(7'b0010010, 1, 0, 0, 0, "R4");
        round(7'b0101000, 0, 1, 2, 4, "R4");
        round(7'b1000001, 1, 1, 0, 0, "R4");
        // R5 R6: linked load once per post.
        post_ll();
        round(7'b0100000, 0, 0, 5, 5, "R5");
        round(7'b0100000, 0, 0, 5, 5, "R5");
        round(7'b1000000, 0, 0, 0, 0, "R8");
        // R7: full-line flush.
        round(7'b0100000, 0, 0, 0, 15, "R7");
        // R1: everything at once.
        post_ll();
        round(7'b1111011, 0, 0, 3, 9, "R1");
        round(7'b1111010, 0, 0, 3, 9, "R1");
        round(7'b1110000, 0, 0, 3, 9, "R1");

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3) == 0) post_ll();
            for (int k = 0; k < 7; k++) r[k] = ($urandom_range(2) == 0);
            a = IW'($urandom); b = IW'($urandom);
            if (a > b) round(r, $urandom_range(3) == 0, $urandom_range(3) == 0, b, a, "R1");
            else       round(r, $urandom_range(3) == 0, $urandom_range(3) == 0, a, b, "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule